// File: doc/BRIEF.md
# Three-Counter Event Monitor

This block counts microarchitectural events on three independent counters and raises a per-counter interrupt pulse once a programmable number of events has been seen. Each counter picks one line out of a shared vector of single-cycle event pulses. Each counter then interrupts either every 256 events or when its full width wraps.

Software drives the unit through a one-cycle command port carrying an opcode and a 64-bit data word. Commands halt all counting, start counting under a per-counter mask, or load the event-select, mode-inhibit and period-select words. A further command overwrites all counter values from one packed 64-bit word. The same packed word is always visible on an output, so a counter can be preloaded to shorten its next interrupt period. An input reporting the current processor mode (user, kernel or PAL) lets counting be suppressed for any mix of those modes.

Top module: `tcpm_unit`

## Requirements
- R1: After reset every counter is zero, no counter runs, no mode is inhibited, and no interrupt is raised.
- R2: The event-select word (opcode 2) gives counter i a select value in bits 8i+7..8i. The counter advances once per cycle in which the selected line of `evt_i` is high. A select value of NUM_EVT or more never advances the counter.
- R3: Opcode 0 stops all counters and opcode 1 sets the run mask from data bits 2..0 (bit i runs counter i). A counter that is not running holds its value.
- R4: Period code 3 makes a counter whose low 8 bits are all ones clear to zero on its next event and raise an interrupt, so it interrupts every 256 events.
- R5: Period code 2 makes a counter interrupt and clear when it wraps its full width: 65536 events for counters 0 and 1, 16384 for counter 2.
- R6: Period codes 0 and 1 raise no interrupt; the counter keeps counting and wraps silently at its full width.
- R7: An interrupt is a one-cycle pulse on `irq_o[i]` for counter i, raised in the cycle the counter first reads zero.
- R8: The mode-inhibit word (opcode 3) suppresses counting in PAL mode with bit 9, in kernel mode with bit 8 and in user mode with bit 30. `mode_i` encodes user as 0, kernel as 1, PAL as 2, and 3 behaves as user.
- R9: `cnt_word_o` carries counter 0 in bits 63:48, counter 1 in bits 47:32 and counter 2 in bits 29:16. All other bits read zero.
- R10: Opcode 6 loads all three counters from the same field positions of the data word. Bit 0 and the other bits outside the fields are ignored.
- R11: A counter load takes priority over any same-cycle increment and suppresses any interrupt in that cycle.
- R12: The period-select word (opcode 4) places counter 0's code in bits 9:8, counter 1's in 7:6 and counter 2's in 5:4. Opcodes 5 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe, one cycle per command |
| cmd_op_i | input | 3 | Command opcode |
| cmd_data_i | input | 64 | Command data word |
| mode_i | input | 2 | Current processor mode |
| evt_i | input | NUM_EVT | Event pulse vector |
| cnt_word_o | output | 64 | Packed counter values |
| irq_o | output | 3 | Interrupt pulse per counter |

## Verification
The assertions check on every cycle the properties that hold whatever the stimulus. They cover the zero padding of the packed word and the zero count seen with every interrupt pulse. They also check that interrupts come only from codes 2 and 3, that counters hold while halted or in an inhibited mode, and that a load lands exactly. Only the bench's scenarios can show that the correct event line is counted. They also show that periods of exactly 256, 65536 and 16384 events come out of a given preload, and that the run mask, the inhibit bits and the unused opcodes act as required. The bench does this by comparing each cycle against a behavioural reference model.

// File: rtl/tcpm_pkg.sv
package tcpm_pkg;

   localparam int NUM_CTR   = 3;
   localparam int WORD_W    = 64;
   localparam int SEL_FLD_W = 8;
   localparam int FLD_W     = 16;

   typedef logic [2:0] op_t;

   localparam op_t OP_HALT    = 3'd0;
   localparam op_t OP_RUN     = 3'd1;
   localparam op_t OP_EVSEL   = 3'd2;
   localparam op_t OP_INHIBIT = 3'd3;
   localparam op_t OP_PERIOD  = 3'd4;
   localparam op_t OP_CNT_WR  = 3'd6;

   localparam logic [1:0] MODE_USER   = 2'd0;
   localparam logic [1:0] MODE_KERNEL = 2'd1;
   localparam logic [1:0] MODE_PAL    = 2'd2;

   // index of each inhibit flag inside the stored 3-bit vector
   localparam int INH_USER   = 0;
   localparam int INH_KERNEL = 1;
   localparam int INH_PAL    = 2;

   // bit positions in the inhibit command word
   localparam int INH_USER_BIT   = 30;
   localparam int INH_KERNEL_BIT = 8;
   localparam int INH_PAL_BIT    = 9;

   // period code of counter 0 sits at its msb, later counters step down by 2
   localparam int PER_MSB0 = 9;

   localparam logic [1:0] PER_SHORT = 2'b11;
   localparam logic [1:0] PER_FULL  = 2'b10;

   function automatic int ctr_lsb(input int idx);
      return 48 - FLD_W * idx;
   endfunction

endpackage

// File: rtl/tcpm_cfg_regs.sv
module tcpm_cfg_regs
   import tcpm_pkg::*;
(
   input  logic                                 clk_i,
   input  logic                                 rst_ni,
   input  logic                                 cmd_valid_i,
   input  op_t                                  cmd_op_i,
   input  logic [WORD_W-1:0]                    cmd_data_i,
   output logic [NUM_CTR-1:0]                   run_o,
   output logic [NUM_CTR-1:0][SEL_FLD_W-1:0]    sel_o,
   output logic [2:0]                           inh_o,
   output logic [NUM_CTR-1:0][1:0]              code_o,
   output logic                                 load_o
);

   logic [NUM_CTR-1:0]                run_q;
   logic [NUM_CTR-1:0][SEL_FLD_W-1:0] sel_q;
   logic [2:0]                        inh_q;
   logic [NUM_CTR-1:0][1:0]           code_q;
   logic                              unused_data;

   assign unused_data = ^cmd_data_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_q  <= '0;
         sel_q  <= '0;
         inh_q  <= '0;
         code_q <= '0;
      end else if (cmd_valid_i) begin
         case (cmd_op_i)
            OP_HALT: run_q <= '0;
            OP_RUN:  run_q <= cmd_data_i[NUM_CTR-1:0];
            OP_EVSEL: begin
               for (int i = 0; i < NUM_CTR; i++)
                  sel_q[i] <= cmd_data_i[SEL_FLD_W*i +: SEL_FLD_W];
            end
            OP_INHIBIT: begin
               inh_q[INH_PAL]    <= cmd_data_i[INH_PAL_BIT];
               inh_q[INH_KERNEL] <= cmd_data_i[INH_KERNEL_BIT];
               inh_q[INH_USER]   <= cmd_data_i[INH_USER_BIT];
            end
            OP_PERIOD: begin
               for (int i = 0; i < NUM_CTR; i++)
                  code_q[i] <= cmd_data_i[PER_MSB0 - 2*i -: 2];
            end
            default: ;
         endcase
      end
   end

   assign run_o  = run_q;
   assign sel_o  = sel_q;
   assign inh_o  = inh_q;
   assign code_o = code_q;
   assign load_o = cmd_valid_i && (cmd_op_i == OP_CNT_WR);

endmodule

// File: rtl/tcpm_evt_gate.sv
module tcpm_evt_gate #(
   parameter int NUM_EVT = 16,
   parameter int SEL_W   = 8
) (
   input  logic [NUM_EVT-1:0] evt_i,
   input  logic [SEL_W-1:0]   sel_i,
   input  logic               run_i,
   input  logic               blocked_i,
   output logic               inc_o
);

   logic hit;

   always_comb begin
      hit = 1'b0;
      for (int k = 0; k < NUM_EVT; k++) begin
         if (sel_i == SEL_W'(k))
            hit = evt_i[k];
      end
   end

   assign inc_o = hit && run_i && !blocked_i;

endmodule

// File: rtl/tcpm_ctr_slice.sv
module tcpm_ctr_slice
   import tcpm_pkg::*;
#(
   parameter int W       = 16,
   parameter int SHORT_W = 8
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         inc_i,
   input  logic [1:0]   code_i,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   output logic [W-1:0] cnt_o,
   output logic         irq_o
);

   logic [W-1:0] cnt_q, cnt_n;
   logic         irq_q, irq_n;
   logic         short_end, full_end, wrap;

   assign short_end = &cnt_q[SHORT_W-1:0];
   assign full_end  = &cnt_q;

   always_comb begin
      wrap = 1'b0;
      if (inc_i) begin
         case (code_i)
            PER_SHORT: wrap = short_end;
            PER_FULL:  wrap = full_end;
            default:   wrap = 1'b0;
         endcase
      end
   end

   always_comb begin
      cnt_n = cnt_q;
      irq_n = 1'b0;
      if (load_i) begin
         cnt_n = load_val_i;
      end else if (wrap) begin
         cnt_n = '0;
         irq_n = 1'b1;
      end else if (inc_i) begin
         cnt_n = cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         irq_q <= 1'b0;
      end else begin
         cnt_q <= cnt_n;
         irq_q <= irq_n;
      end
   end

   assign cnt_o = cnt_q;
   assign irq_o = irq_q;

endmodule

// File: rtl/tcpm_unit.sv
module tcpm_unit
   import tcpm_pkg::*;
#(
   parameter int NUM_EVT = 16,
   parameter int CNT_A_W = 16,
   parameter int CNT_B_W = 14,
   parameter int SHORT_W = 8
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               cmd_valid_i,
   input  logic [2:0]         cmd_op_i,
   input  logic [63:0]        cmd_data_i,
   input  logic [1:0]         mode_i,
   input  logic [NUM_EVT-1:0] evt_i,
   output logic [63:0]        cnt_word_o,
   output logic [2:0]         irq_o
);

   localparam int PAD_W = WORD_W - NUM_CTR * FLD_W;

   if (NUM_EVT < 1 || NUM_EVT > 256) begin : g_bad_evt
      $error("NUM_EVT must lie in 1..256");
   end
   if (CNT_A_W <= SHORT_W || CNT_A_W > FLD_W) begin : g_bad_a
      $error("CNT_A_W must exceed SHORT_W and fit 16 bits");
   end
   if (CNT_B_W <= SHORT_W || CNT_B_W > FLD_W - 2) begin : g_bad_b
      $error("CNT_B_W must exceed SHORT_W and fit 14 bits");
   end

   logic [NUM_CTR-1:0]                run_w;
   logic [NUM_CTR-1:0][SEL_FLD_W-1:0] sel_w;
   logic [2:0]                        inh_w;
   logic [NUM_CTR-1:0][1:0]           code_w;
   logic                              load_w;
   logic                              blocked_w;
   logic [NUM_CTR-1:0][FLD_W-1:0]     cnt_ext;

   tcpm_cfg_regs u_cfg (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cmd_valid_i (cmd_valid_i),
      .cmd_op_i    (cmd_op_i),
      .cmd_data_i  (cmd_data_i),
      .run_o       (run_w),
      .sel_o       (sel_w),
      .inh_o       (inh_w),
      .code_o      (code_w),
      .load_o      (load_w)
   );

   always_comb begin
      case (mode_i)
         MODE_PAL:    blocked_w = inh_w[INH_PAL];
         MODE_KERNEL: blocked_w = inh_w[INH_KERNEL];
         default:     blocked_w = inh_w[INH_USER];
      endcase
   end

   for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
      localparam int W   = (g == NUM_CTR - 1) ? CNT_B_W : CNT_A_W;
      localparam int LSB = ctr_lsb(g);

      logic         inc_w;
      logic [W-1:0] cnt_w;

      tcpm_evt_gate #(
         .NUM_EVT (NUM_EVT),
         .SEL_W   (SEL_FLD_W)
      ) u_gate (
         .evt_i     (evt_i),
         .sel_i     (sel_w[g]),
         .run_i     (run_w[g]),
         .blocked_i (blocked_w),
         .inc_o     (inc_w)
      );

      tcpm_ctr_slice #(
         .W       (W),
         .SHORT_W (SHORT_W)
      ) u_slice (
         .clk_i      (clk_i),
         .rst_ni     (rst_ni),
         .inc_i      (inc_w),
         .code_i     (code_w[g]),
         .load_i     (load_w),
         .load_val_i (cmd_data_i[LSB +: W]),
         .cnt_o      (cnt_w),
         .irq_o      (irq_o[g])
      );

      if (W < FLD_W) begin : g_pad
         assign cnt_ext[g] = {{(FLD_W - W){1'b0}}, cnt_w};
      end else begin : g_full
         assign cnt_ext[g] = cnt_w;
      end
   end

   assign cnt_word_o = {cnt_ext[0], cnt_ext[1], cnt_ext[2], {PAD_W{1'b0}}};

endmodule

// File: rtl/tcpm_chk.sv
module tcpm_chk
   import tcpm_pkg::*;
#(
   parameter int CA = 16,
   parameter int CB = 14
) (
   input logic        clk_i,
   input logic        rst_ni,
   input logic        cmd_valid_i,
   input logic [2:0]  cmd_op_i,
   input logic [63:0] cmd_data_i,
   input logic [1:0]  mode_i,
   input logic [63:0] cnt_word_o,
   input logic [2:0]  irq_o,
   input logic [2:0]  run_w,
   input logic [2:0]  inh_w,
   input logic [2:0][1:0] code_w
);

   localparam logic [63:0] FMASK_A = (64'(1) << CA) - 64'(1);
   localparam logic [63:0] FMASK_B = (64'(1) << CB) - 64'(1);
   localparam logic [63:0] WMASK   = (FMASK_A << 48) | (FMASK_A << 32) | (FMASK_B << 16);

   logic load_c;
   assign load_c = cmd_valid_i && (cmd_op_i == OP_CNT_WR);

   // R1
   reset_zero_chk: assert property (@(posedge clk_i)
      !rst_ni |=> (cnt_word_o == 64'd0 && irq_o == 3'd0));

   // R9
   pad_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_word_o & ~WMASK) == 64'd0);

   // R7
   irq0_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[0] |-> cnt_word_o[63:48] == 16'd0);
   // R7
   irq1_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[1] |-> cnt_word_o[47:32] == 16'd0);
   // R7
   irq2_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[2] |-> cnt_word_o[29:16] == 14'd0);
   // R7
   irq_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_o != 3'd0) |=> ((irq_o & $past(irq_o)) == 3'd0));

   // R6
   irq0_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[0] |-> $past(code_w[0][1]));
   // R6
   irq2_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[2] |-> $past(code_w[2][1]));

   // R3
   halt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(!run_w[0]) && !$past(load_c)) |-> cnt_word_o[63:48] == $past(cnt_word_o[63:48]));

   // R8
   pal_inh_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(mode_i == MODE_PAL && inh_w[INH_PAL] && !load_c) |-> $stable(cnt_word_o));
   // R8
   kern_inh_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(mode_i == MODE_KERNEL && inh_w[INH_KERNEL] && !load_c) |-> $stable(cnt_word_o));

   // R11
   load_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(load_c) |-> (cnt_word_o == ($past(cmd_data_i) & WMASK) && irq_o == 3'd0));

endmodule

bind tcpm_unit tcpm_chk #(
   .CA (CNT_A_W),
   .CB (CNT_B_W)
) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .cmd_valid_i (cmd_valid_i),
   .cmd_op_i    (cmd_op_i),
   .cmd_data_i  (cmd_data_i),
   .mode_i      (mode_i),
   .cnt_word_o  (cnt_word_o),
   .irq_o       (irq_o),
   .run_w       (run_w),
   .inh_w       (inh_w),
   .code_w      (code_w)
);

// File: tb/tcpm_unit_tb_top.sv
`timescale 1ns/1ps
module tcpm_unit_tb_top;

   localparam int NUM_EVT = 16;

   logic               clk = 1'b0;
   logic               rst_ni = 1'b0;
   logic               cmd_valid = 1'b0;
   logic [2:0]         cmd_op = 3'd0;
   logic [63:0]        cmd_data = 64'd0;
   logic [1:0]         mode = 2'd0;
   logic [NUM_EVT-1:0] evt = '0;
   logic [63:0]        cnt_word;
   logic [2:0]         irq;

   int    n_cmp = 0;
   int    n_bad = 0;
   bit    done  = 0;
   string tag   = "R1";

   int m_cnt  [3];
   bit m_run  [3];
   int m_sel  [3];
   bit m_inh  [3];
   int m_code [3];
   bit m_irq  [3];

   always #2 clk = ~clk;

   tcpm_unit #(.NUM_EVT(NUM_EVT)) dut_i (
      .clk_i       (clk),
      .rst_ni      (rst_ni),
      .cmd_valid_i (cmd_valid),
      .cmd_op_i    (cmd_op),
      .cmd_data_i  (cmd_data),
      .mode_i      (mode),
      .evt_i       (evt),
      .cnt_word_o  (cnt_word),
      .irq_o       (irq)
   );

   function automatic int wdt(input int i);
      return (i == 2) ? 14 : 16;
   endfunction

   function automatic logic [63:0] m_word();
      return {16'(m_cnt[0]), 16'(m_cnt[1]), 2'b00, 14'(m_cnt[2]), 16'h0000};
   endfunction

   function automatic void model_reset();
      for (int i = 0; i < 3; i++) begin
         m_cnt[i] = 0; m_run[i] = 0; m_sel[i] = 0;
         m_inh[i] = 0; m_code[i] = 0; m_irq[i] = 0;
      end
   endfunction

   function automatic void model_step();
      bit blk;
      for (int i = 0; i < 3; i++) m_irq[i] = 0;
      if (mode == 2'd2)      blk = m_inh[2];
      else if (mode == 2'd1) blk = m_inh[1];
      else                   blk = m_inh[0];
      if (cmd_valid && cmd_op == 3'd6) begin
         m_cnt[0] = int'(cmd_data[63:48]);
         m_cnt[1] = int'(cmd_data[47:32]);
         m_cnt[2] = int'(cmd_data[29:16]);
      end else begin
         for (int i = 0; i < 3; i++) begin
            if (m_run[i] && !blk && m_sel[i] < NUM_EVT && evt[m_sel[i]]) begin
               int top;
               top = (1 << wdt(i)) - 1;
               if ((m_code[i] == 3 && (m_cnt[i] % 256) == 255) ||
                   (m_code[i] == 2 && m_cnt[i] == top)) begin
                  m_cnt[i] = 0;
                  m_irq[i] = 1;
               end else begin
                  m_cnt[i] = (m_cnt[i] + 1) & top;
               end
            end
         end
      end
      if (cmd_valid) begin
         case (cmd_op)
            3'd0: for (int i = 0; i < 3; i++) m_run[i] = 0;
            3'd1: for (int i = 0; i < 3; i++) m_run[i] = cmd_data[i];
            3'd2: for (int i = 0; i < 3; i++) m_sel[i] = int'(cmd_data[8*i +: 8]);
            3'd3: begin
               m_inh[2] = cmd_data[9];
               m_inh[1] = cmd_data[8];
               m_inh[0] = cmd_data[30];
            end
            3'd4: for (int i = 0; i < 3; i++) m_code[i] = int'(cmd_data[9 - 2*i -: 2]);
            default: ;
         endcase
      end
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      if (rst_ni) model_step();
      else        model_reset();
      #1;
      chk(tag, cnt_word, m_word());
      chk(tag, 64'(irq), 64'({m_irq[2], m_irq[1], m_irq[0]}));
   endtask

   task automatic cmd(input logic [2:0] op, input logic [63:0] data);
      cmd_valid = 1'b1;
      cmd_op    = op;
      cmd_data  = data;
      tick();
      cmd_valid = 1'b0;
      cmd_data  = 64'd0;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         evt = NUM_EVT'($urandom);
         tick();
      end
      evt = '0;
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [63:0] snap;
      model_reset();
      repeat (3) tick();
      rst_ni = 1'b1;
      // R1: reset state
      tag = "R1";
      chk("R1", cnt_word, 64'd0);
      chk("R1", 64'(irq), 64'd0);
      idle(20);
      chk("R1", cnt_word, 64'd0);

      // R2: event selection
      tag = "R2";
      cmd(3'd2, {40'd0, 8'd9, 8'd5, 8'd3});
      cmd(3'd1, 64'd7);
      idle(200);
      cmd(3'd2, {40'd0, 8'd40, 8'd5, 8'd3});
      snap = cnt_word;
      idle(100);
      chk("R2", 64'(cnt_word[29:16]), 64'(snap[29:16]));

      // R3: halt and run mask
      tag = "R3";
      cmd(3'd0, 64'd0);
      snap = cnt_word;
      idle(50);
      chk("R3", cnt_word, snap);
      cmd(3'd1, 64'd2);
      idle(100);

      // R4: 256-event period with preload
      tag = "R4";
      cmd(3'd4, 64'h300);
      cmd(3'd1, 64'd1);
      cmd(3'd6, 64'h12F0_0000_0000_0000);
      evt = '1;
      for (int k = 0; k < 15; k++) tick();
      chk("R4", 64'(cnt_word[63:48]), 64'h12FF);
      tick();
      chk("R4", 64'(cnt_word[63:48]), 64'h0);
      chk("R7", 64'(irq), 64'd1);
      evt = '0;
      tick();
      chk("R7", 64'(irq), 64'd0);
      idle(600);

      // R5: full-width period
      tag = "R5";
      cmd(3'd0, 64'd0);
      cmd(3'd4, 64'h220);
      cmd(3'd2, {40'd0, 8'd3, 8'd5, 8'd3});
      cmd(3'd6, 64'hFFFE_0000_3FFE_0000);
      cmd(3'd1, 64'd5);
      evt = 16'h0008;
      tick();
      chk("R5", cnt_word, 64'hFFFF_0000_3FFF_0000);
      tick();
      chk("R5", 64'(irq), 64'd5);
      chk("R5", cnt_word, 64'd0);
      evt = '0;
      idle(300);

      // R6: codes without interrupt
      tag = "R6";
      cmd(3'd0, 64'd0);
      cmd(3'd4, 64'h040);
      cmd(3'd6, 64'h0000_FFFD_0000_0000);
      cmd(3'd1, 64'd2);
      evt = 16'h0020;
      for (int k = 0; k < 3; k++) begin
         tick();
         chk("R6", 64'(irq), 64'd0);
      end
      chk("R6", cnt_word, 64'd0);
      evt = '0;
      cmd(3'd1, 64'd7);
      idle(200);

      // R8: mode inhibit
      tag = "R8";
      cmd(3'd3, 64'h100);
      mode = 2'd1;
      snap = cnt_word;
      evt = '1;
      for (int k = 0; k < 10; k++) tick();
      chk("R8", cnt_word, snap);
      evt = '0;
      for (int p = 0; p < 8; p++) begin
         cmd(3'd3, (64'(p & 1) << 9) | (64'((p >> 1) & 1) << 8) | (64'((p >> 2) & 1) << 30));
         for (int k = 0; k < 40; k++) begin
            mode = 2'($urandom);
            evt  = NUM_EVT'($urandom);
            tick();
         end
      end
      mode = 2'd0;
      evt  = '0;
      cmd(3'd3, 64'd0);

      // R9, R10: layout and ignored bits
      tag = "R10";
      cmd(3'd6, {64{1'b1}});
      chk("R9", cnt_word, 64'hFFFF_FFFF_3FFF_0000);
      cmd(3'd6, 64'h0000_0000_0000_0001);
      chk("R10", cnt_word, 64'd0);

      // R11: load beats increment
      tag = "R11";
      cmd(3'd4, 64'h3F0);
      cmd(3'd1, 64'd7);
      cmd(3'd6, 64'h12FF_FFFF_3FFF_0000);
      evt = '1;
      cmd_valid = 1'b1;
      cmd_op    = 3'd6;
      cmd_data  = 64'h1234_5678_0ABC_0000;
      tick();
      cmd_valid = 1'b0;
      chk("R11", cnt_word, 64'h1234_5678_0ABC_0000);
      chk("R11", 64'(irq), 64'd0);
      evt = '0;

      // R12: period layout and no-op opcodes
      tag = "R12";
      snap = cnt_word;
      cmd(3'd5, {64{1'b1}});
      cmd(3'd7, {64{1'b1}});
      chk("R12", cnt_word, snap);
      cmd(3'd4, 64'h1B0);
      idle(600);

      done = 1;
      summary();
      $finish;
   end

endmodule